// File: doc/BRIEF.md
# Burst SRAM Cycle and Write Controller

This block decodes the synchronous control pins of a flow-through burst SRAM on every rising clock edge. It sorts each cycle into one of these kinds: idle, deselect, read start, write start, burst continue or burst suspend. From that decision it produces per-lane write strobes, a chip-active flag and an enable for the output drivers. A small behavioural word array sits behind the controller. A two-bit burst sequencer walks the low address bits through four words, in linear or interleaved order.

Two load strobes can start an access. The processor-side strobe is qualified by the chip enable, and the cycle it starts is always a read. Any write that follows it happens on a later cycle. The controller-side strobe can start a read or a write in its own cycle. When no strobe is taken, the advance input either steps the burst address or holds it, and the write controls decide whether that cycle reads or writes. Read data leaves the array combinationally from the registered address, with no output register. The output drivers are gated asynchronously by output enable and by the sleep input. While sleep is high nothing is stored. After waking, the controller accepts nothing until it sees a deselect cycle.

Top module: `burst_sram_ctl`

## Requirements
- R1: The part is selected when chipEnN=0, chipSelHi=1 and chipSelLoN=0. A load strobe taken while not selected gives cycleKind=1 (deselect), clears chipActive and leaves dataOutEn low. When chipEnN=1 the processor strobe is not a load. With no load strobe and chipActive=0, cycleKind=0 (idle).
- R2: A selected loadProcN=0 cycle is a read start (cycleKind=2) at the external address, and it writes nothing whatever gwN, bweN and byteSelN are. A write driven on the next cycle, with no strobe, is applied.
- R3: A selected loadCtlN=0 cycle with an active write control is a write start (cycleKind=3) at the external address. Following cycles with advN=0 and a write control are continue writes (cycleKind=4) at the next burst address.
- R4: gwN=0 writes all four lanes, whatever bweN and byteSelN are.
- R5: With gwN=1 and bweN=0, each byteSelN[i]=0 writes lane i, which is dataIn[9i+8:9i] into word bits [9i+8:9i]. Several lanes may be written in one cycle, and the other lanes keep their contents.
- R6: With gwN=1 and bweN=1 the byte selects are blocked. The cycle is a read and the word is unchanged.
- R7: After any cycle that writes a lane (byteWrite non-zero), dataOutEn is 0.
- R8: After a read edge, dataOut equals the addressed word during that same clock period. dataOutEn = 0 whenever oeN=1, with no clock edge needed.
- R9: With no load strobe, advN=0 steps the burst count (cycleKind=4) and advN=1 holds the address (cycleKind=5). The two low address bits are base+count mod 4 when interleave=0, and base XOR count when interleave=1. The sequence wraps to the base after four words.
- R10: If both strobes are low while the part is selected, the processor strobe wins: the cycle is a read start and nothing is written.
- R11: While sleep=1 no write, address or cycle state is stored, and dataOutEn is 0. After waking, the outputs stay off, and every load or burst cycle reads as cycleKind=0 until a deselect cycle is seen.
- R12: After reset, cycleKind=0, chipActive=0, byteWrite=0 and dataOutEn=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| chipEnN | input | 1 | Active-low chip enable; also qualifies loadProcN |
| chipSelHi | input | 1 | Active-high chip select |
| chipSelLoN | input | 1 | Active-low chip select |
| loadProcN | input | 1 | Processor-side address load strobe, active low |
| loadCtlN | input | 1 | Controller-side address load strobe, active low |
| advN | input | 1 | Burst advance, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| byteSelN | input | 4 | Per-lane write selects, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear; held static |
| addr | input | ADDR_W | External word address |
| dataIn | input | 36 | Write data, four 9-bit lanes |
| dataOut | output | 36 | Flow-through read data |
| dataOutEn | output | 1 | Drive enable for the data bus |
| cycleKind | output | 3 | Last stored cycle: 0 idle, 1 deselect, 2 read start, 3 write start, 4 continue, 5 suspend |
| chipActive | output | 1 | Set by a load, cleared by a deselect |
| byteWrite | output | 4 | Lanes written at the last edge |

## Verification
The hardest case to reach from the ports is the wake-up guard. The part has to be in an active read, then sleep while strobes and write controls keep toggling, then wake and see a load refused before a deselect re-arms it. The bench builds this as one directed sequence. It writes a known word first, then attempts a write to that word during sleep, and reads the word back only after the deselect. This shows both that the sleeping edge stored nothing and that the refused load did nothing. The deferred write after a processor-started read is reached the same way: the bench follows the read with a suspend cycle that carries the write data.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int LANE_CNT = 4;

  typedef enum logic [2:0] {
    KIND_IDLE     = 3'd0,
    KIND_DESEL    = 3'd1,
    KIND_RD_BEGIN = 3'd2,
    KIND_WR_BEGIN = 3'd3,
    KIND_CONT     = 3'd4,
    KIND_SUSP     = 3'd5
  } cycKind_e;

  // Strobes handed from the cycle decoder to the datapath
  typedef struct packed {
    logic                load;
    logic                advance;
    logic [LANE_CNT-1:0] wr;
  } strobe_t;
endpackage

// File: rtl/bsc_control.sv
module bsc_control
  import bsc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                chipEnN,
  input  logic                chipSelHi,
  input  logic                chipSelLoN,
  input  logic                loadProcN,
  input  logic                loadCtlN,
  input  logic                advN,
  input  logic                gwN,
  input  logic                bweN,
  input  logic [LANE_CNT-1:0] byteSelN,
  input  logic                sleep,
  output strobe_t             strb,
  output cycKind_e            kindQ,
  output logic                chipActive,
  output logic                readOn,
  output logic [LANE_CNT-1:0] wrQ
);
  logic selected, procLoad, ctlLoad, wakeGuard;
  logic [LANE_CNT-1:0] wrMask;
  cycKind_e kindD;

  assign selected = !chipEnN && chipSelHi && !chipSelLoN;
  assign procLoad = !loadProcN && !chipEnN;
  assign ctlLoad  = !loadCtlN;

  // Hierarchical write gating: global write over byte enable over lane selects
  always_comb begin
    if (!gwN)       wrMask = '1;
    else if (!bweN) wrMask = ~byteSelN;
    else            wrMask = '0;
  end

  always_comb begin
    strb  = '0;
    kindD = KIND_IDLE;
    if (!sleep) begin
      if ((procLoad || ctlLoad) && !selected) begin
        kindD = KIND_DESEL;
      end else if ((procLoad || ctlLoad) && wakeGuard) begin
        kindD = KIND_IDLE;
      end else if (procLoad) begin
        strb.load = 1'b1;
        kindD     = KIND_RD_BEGIN;
      end else if (ctlLoad) begin
        strb.load = 1'b1;
        strb.wr   = wrMask;
        kindD     = (|wrMask) ? KIND_WR_BEGIN : KIND_RD_BEGIN;
      end else if (chipActive && !wakeGuard) begin
        strb.advance = !advN;
        strb.wr      = wrMask;
        kindD        = advN ? KIND_SUSP : KIND_CONT;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ      <= KIND_IDLE;
      chipActive <= 1'b0;
      readOn     <= 1'b0;
      wrQ        <= '0;
      wakeGuard  <= 1'b0;
    end else if (sleep) begin
      wakeGuard <= 1'b1;
      readOn    <= 1'b0;
    end else begin
      kindQ <= kindD;
      wrQ   <= strb.wr;
      if (kindD == KIND_DESEL) begin
        chipActive <= 1'b0;
        wakeGuard  <= 1'b0;
      end else if (strb.load) begin
        chipActive <= 1'b1;
      end
      readOn <= (kindD == KIND_RD_BEGIN) ||
                (((kindD == KIND_CONT) || (kindD == KIND_SUSP)) && (strb.wr == '0));
    end
  end

  assert_desel_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (kindQ == KIND_DESEL) |-> !chipActive);

  // R2 and R10: a selected processor strobe never writes
  assert_proc_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !wakeGuard && !loadProcN && !chipEnN && chipSelHi && !chipSelLoN)
    |=> (wrQ == '0 && kindQ == KIND_RD_BEGIN));

  assert_global_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !wakeGuard && loadProcN && !loadCtlN && !gwN && selected) |=> (&wrQ));

  assert_sleep_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> ($stable(chipActive) && $stable(kindQ) && !readOn));
endmodule

// File: rtl/bsc_datapath.sv
module bsc_datapath
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic                       interleave,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANE_CNT*LANE_W-1:0] dataIn,
  output logic [LANE_CNT*LANE_W-1:0] dataOut
);
  localparam int DATA_W = LANE_CNT * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:2] addrHi;
  logic [1:0]        base, cnt, cntNext;
  logic [ADDR_W-1:0] curAddr, effAddr;

  function automatic logic [1:0] burstLow(input logic [1:0] b, input logic [1:0] c,
                                          input logic ilv);
    return ilv ? (b ^ c) : 2'(b + c);
  endfunction

  assign cntNext = 2'(cnt + 2'd1);
  assign curAddr = {addrHi, burstLow(base, cnt, interleave)};
  assign effAddr = strb.load    ? addr :
                   strb.advance ? {addrHi, burstLow(base, cntNext, interleave)} : curAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi <= '0;
      base   <= '0;
      cnt    <= '0;
    end else if (strb.load) begin
      addrHi <= addr[ADDR_W-1:2];
      base   <= addr[1:0];
      cnt    <= '0;
    end else if (strb.advance) begin
      cnt <= cntNext;
    end
  end

  // Write data sampled at the edge straight into the array lanes
  always_ff @(posedge clk) begin
    for (int g = 0; g < LANE_CNT; g++) begin
      if (strb.wr[g]) mem[effAddr][g*LANE_W +: LANE_W] <= dataIn[g*LANE_W +: LANE_W];
    end
  end

  // Flow-through read: no output register
  assign dataOut = mem[curAddr];

  assert_suspend_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.advance) |=> $stable(cnt) && $stable(base) && $stable(addrHi));
endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       chipEnN,
  input  logic                       chipSelHi,
  input  logic                       chipSelLoN,
  input  logic                       loadProcN,
  input  logic                       loadCtlN,
  input  logic                       advN,
  input  logic                       gwN,
  input  logic                       bweN,
  input  logic [LANE_CNT-1:0]        byteSelN,
  input  logic                       oeN,
  input  logic                       sleep,
  input  logic                       interleave,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANE_CNT*LANE_W-1:0] dataIn,
  output logic [LANE_CNT*LANE_W-1:0] dataOut,
  output logic                       dataOutEn,
  output logic [2:0]                 cycleKind,
  output logic                       chipActive,
  output logic [LANE_CNT-1:0]        byteWrite
);
  strobe_t  strb;
  cycKind_e kindQ;
  logic     readOn;

  bsc_control u_control (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .chipSelHi(chipSelHi),
    .chipSelLoN(chipSelLoN), .loadProcN(loadProcN), .loadCtlN(loadCtlN),
    .advN(advN), .gwN(gwN), .bweN(bweN), .byteSelN(byteSelN), .sleep(sleep),
    .strb(strb), .kindQ(kindQ), .chipActive(chipActive), .readOn(readOn),
    .wrQ(byteWrite)
  );

  bsc_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .interleave(interleave),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut)
  );

  assign cycleKind = kindQ;
  assign dataOutEn = readOn && !oeN && !sleep;

  assert_write_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|byteWrite) |-> !dataOutEn);

  assert_oe_async_R8: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dataOutEn);
endmodule

// File: tb/tb_burst_sram_ctl.sv
module tb_burst_sram_ctl;
  localparam int CLK_PERIOD = 10;
  localparam bit L = 1'b0;
  localparam bit H = 1'b1;

  typedef struct packed {
    bit cen, csh, csln, lp, lc, adv, gw, bwe;
    bit [3:0] bs;
    bit oe;
    bit [3:0] a;
    bit [35:0] din;
    bit [2:0] kind;
    bit en;
    bit [35:0] exp;
    bit [7:0] req;
  } row_t;

  function automatic bit [35:0] pat(input int k);
    return {9'(k + 192), 9'(k + 128), 9'(k + 64), 9'(k)};
  endfunction

  // lane i from newv where mask[i]==0, else from oldv
  function automatic bit [35:0] mix(input bit [3:0] mask, input bit [35:0] oldv,
                                    input bit [35:0] newv);
    bit [35:0] r;
    for (int i = 0; i < 4; i++) r[i*9 +: 9] = mask[i] ? oldv[i*9 +: 9] : newv[i*9 +: 9];
    return r;
  endfunction

  localparam bit [35:0] Z = 36'd0;
  localparam int N = 32;
  localparam row_t ROWS [N] = '{
    // R3: write start at 4, then continue writes 5,6,7
    '{L,H,L,H,L,H,L,H,4'hF,L,4'd4,pat(1),3'd3,L,Z,8'd3},
    '{L,H,L,H,H,L,L,H,4'hF,L,4'd0,pat(2),3'd4,L,Z,8'd3},
    '{L,H,L,H,H,L,L,H,4'hF,L,4'd0,pat(3),3'd4,L,Z,8'd3},
    '{L,H,L,H,H,L,L,H,4'hF,L,4'd0,pat(4),3'd4,L,Z,8'd3},
    // R8 R9: read 4, linear burst with suspend and wrap
    '{L,H,L,L,H,H,H,H,4'hF,L,4'd4,Z,3'd2,H,pat(1),8'd8},
    '{L,H,L,H,H,L,H,H,4'hF,L,4'd0,Z,3'd4,H,pat(2),8'd9},
    '{L,H,L,H,H,H,H,H,4'hF,L,4'd0,Z,3'd5,H,pat(2),8'd9},
    '{L,H,L,H,H,L,H,H,4'hF,L,4'd0,Z,3'd4,H,pat(3),8'd9},
    '{L,H,L,H,H,L,H,H,4'hF,L,4'd0,Z,3'd4,H,pat(4),8'd9},
    '{L,H,L,H,H,L,H,H,4'hF,L,4'd0,Z,3'd4,H,pat(1),8'd9},
    // R9: linear from base 2: 6,7,4,5
    '{L,H,L,L,H,H,H,H,4'hF,L,4'd6,Z,3'd2,H,pat(3),8'd9},
    '{L,H,L,H,H,L,H,H,4'hF,L,4'd0,Z,3'd4,H,pat(4),8'd9},
    '{L,H,L,H,H,L,H,H,4'hF,L,4'd0,Z,3'd4,H,pat(1),8'd9},
    '{L,H,L,H,H,L,H,H,4'hF,L,4'd0,Z,3'd4,H,pat(2),8'd9},
    // R2: write 9, processor read ignores gw, suspend applies deferred write
    '{L,H,L,H,L,H,L,H,4'hF,L,4'd9,pat(12),3'd3,L,Z,8'd3},
    '{L,H,L,L,H,H,L,H,4'hF,L,4'd9,pat(13),3'd2,H,pat(12),8'd2},
    '{L,H,L,H,H,H,L,H,4'hF,L,4'd0,pat(14),3'd5,L,Z,8'd2},
    '{L,H,L,H,L,H,H,H,4'hF,L,4'd9,Z,3'd2,H,pat(14),8'd2},
    // R10: both strobes low -> read, no write
    '{L,H,L,L,L,H,L,H,4'hF,L,4'd9,pat(15),3'd2,H,pat(14),8'd10},
    '{L,H,L,H,L,H,H,H,4'hF,L,4'd9,Z,3'd2,H,pat(14),8'd10},
    // R5: lanes 0 and 2
    '{L,H,L,H,L,H,H,L,4'b1010,L,4'd9,pat(16),3'd3,L,Z,8'd5},
    '{L,H,L,H,L,H,H,H,4'hF,L,4'd9,Z,3'd2,H,mix(4'b1010,pat(14),pat(16)),8'd5},
    // R6: byte selects blocked
    '{L,H,L,H,L,H,H,H,4'h0,L,4'd9,pat(17),3'd2,H,mix(4'b1010,pat(14),pat(16)),8'd6},
    // R4 R7: global write over byte controls
    '{L,H,L,H,L,H,L,L,4'hE,L,4'd9,pat(18),3'd3,L,Z,8'd7},
    // R8: oe high keeps the bus off
    '{L,H,L,H,L,H,H,H,4'hF,H,4'd9,Z,3'd2,L,Z,8'd8},
    '{L,H,L,H,L,H,H,H,4'hF,L,4'd9,Z,3'd2,H,pat(18),8'd4},
    // R1: deselect, idle continue, gated processor strobe, selects
    '{H,H,L,H,L,H,H,H,4'hF,L,4'd4,Z,3'd1,L,Z,8'd1},
    '{L,H,L,H,H,L,H,H,4'hF,L,4'd0,Z,3'd0,L,Z,8'd1},
    '{H,H,L,L,H,H,H,H,4'hF,L,4'd4,Z,3'd0,L,Z,8'd1},
    '{L,L,L,H,L,H,H,H,4'hF,L,4'd4,Z,3'd1,L,Z,8'd1},
    '{L,H,H,H,L,H,H,H,4'hF,L,4'd4,Z,3'd1,L,Z,8'd1},
    '{L,H,L,H,L,H,H,H,4'hF,L,4'd4,Z,3'd2,H,pat(1),8'd1}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic chipEnN, chipSelHi, chipSelLoN, loadProcN, loadCtlN, advN, gwN, bweN;
  logic [3:0] byteSelN;
  logic oeN, sleep, interleave;
  logic [3:0] addr;
  logic [35:0] dataIn, dataOut;
  logic dataOutEn, chipActive;
  logic [2:0] cycleKind;
  logic [3:0] byteWrite;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram_ctl dut (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .chipSelHi(chipSelHi),
    .chipSelLoN(chipSelLoN), .loadProcN(loadProcN), .loadCtlN(loadCtlN),
    .advN(advN), .gwN(gwN), .bweN(bweN), .byteSelN(byteSelN), .oeN(oeN),
    .sleep(sleep), .interleave(interleave), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .cycleKind(cycleKind),
    .chipActive(chipActive), .byteWrite(byteWrite)
  );

  task automatic check(input string what, input int req, input logic [35:0] act,
                       input logic [35:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    chipEnN = r.cen; chipSelHi = r.csh; chipSelLoN = r.csln;
    loadProcN = r.lp; loadCtlN = r.lc; advN = r.adv; gwN = r.gw; bweN = r.bwe;
    byteSelN = r.bs; oeN = r.oe; addr = r.a; dataIn = r.din;
  endtask

  task automatic setIdle();
    drive('{L,H,L,H,H,H,H,H,4'hF,L,4'd0,Z,3'd0,L,Z,8'd0});
  endtask

  task automatic stepRead(input logic [3:0] a, input bit proc);
    setIdle(); addr = a;
    if (proc) loadProcN = 1'b0; else loadCtlN = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    sleep = 1'b0; interleave = 1'b0;
    setIdle();
    repeat (2) @(posedge clk);
    #1;
    // R12: reset state
    check("reset kind", 12, 36'(cycleKind), 36'd0);
    check("reset active", 12, 36'(chipActive), 36'd0);
    check("reset outEn", 12, 36'(dataOutEn), 36'd0);
    check("reset byteWrite", 12, 36'(byteWrite), 36'd0);
    rstN = 1'b1;

    for (int i = 0; i < N; i++) begin
      drive(ROWS[i]);
      @(posedge clk); #1;
      check($sformatf("row %0d kind", i), int'(ROWS[i].req), 36'(cycleKind), 36'(ROWS[i].kind));
      check($sformatf("row %0d outEn", i), int'(ROWS[i].req), 36'(dataOutEn), 36'(ROWS[i].en));
      if (ROWS[i].en) check($sformatf("row %0d data", i), int'(ROWS[i].req), dataOut, ROWS[i].exp);
    end

    // R9: interleaved order from base 1 -> 5,4,7,6
    setIdle(); chipEnN = 1'b1; loadCtlN = 1'b0;
    @(posedge clk); #1;
    interleave = 1'b1;
    stepRead(4'd5, 1'b1);
    check("ilv first", 9, dataOut, pat(2));
    setIdle(); advN = 1'b0; @(posedge clk); #1;
    check("ilv second", 9, dataOut, pat(1));
    @(posedge clk); #1;
    check("ilv third", 9, dataOut, pat(4));
    @(posedge clk); #1;
    check("ilv fourth", 9, dataOut, pat(3));
    check("ilv kind", 9, 36'(cycleKind), 36'd4);
    interleave = 1'b0;

    // R11: sleep and wake guard
    stepRead(4'd4, 1'b0);
    check("pre-sleep data", 11, dataOut, pat(1));
    sleep = 1'b1; loadCtlN = 1'b0; gwN = 1'b0; addr = 4'd4; dataIn = pat(30);
    #1;
    check("sleep outEn async", 11, 36'(dataOutEn), 36'd0);
    @(posedge clk); #1;
    check("sleep kind held", 11, 36'(cycleKind), 36'd2);
    check("sleep active held", 11, 36'(chipActive), 36'd1);
    sleep = 1'b0; setIdle(); #1;
    check("wake outEn", 11, 36'(dataOutEn), 36'd0);
    stepRead(4'd5, 1'b0);
    check("wake load ignored kind", 11, 36'(cycleKind), 36'd0);
    check("wake load ignored outEn", 11, 36'(dataOutEn), 36'd0);
    setIdle(); advN = 1'b0; @(posedge clk); #1;
    check("wake burst ignored", 11, 36'(cycleKind), 36'd0);
    setIdle(); chipEnN = 1'b1; loadCtlN = 1'b0; @(posedge clk); #1;
    check("wake deselect", 11, 36'(cycleKind), 36'd1);
    stepRead(4'd4, 1'b0);
    check("after wake kind", 11, 36'(cycleKind), 36'd2);
    check("sleep write dropped", 11, dataOut, pat(1));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule